// File: doc/BRIEF.md
# Front Panel Display and Keypad Controller

This block takes all front-panel work away from a host processor. It scans a six-digit seven-segment LED display on its own, one digit at a time, and holds a bank of eight status LEDs. It also filters seven key switches and flags every debounced press and every release with a level interrupt, so the host does not have to poll.

The host reaches the block over a four-line multiplexed bus. While `ale_i` is high the lines carry a register address. After `ale_i` falls, one write strobe moves one data nibble into the block, or one read strobe puts one nibble on `bus_o`. Registers 0 to 5 hold raw segment patterns for digits 0 to 5. Register 6 holds the status LEDs. Register 7 holds the filtered key levels and the change flag. Each eight-bit register is reached as two nibbles, chosen by address bit 3.

All bus inputs are taken as synchronous to `clk_i`.

Top module: `fpanel_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `seg_o`, `led_o`, `irq_o` and `bus_oe_o` are all zero and `digit_en_o` is 6'b000001. No key is recorded as changed.
- R2: `digit_en_o` always has exactly one bit set. After reset, bit 0 is the first digit driven. Each digit stays driven for 2^SCAN_LOG2 clocks. The enables step 0,1,2,3,4,5 and then wrap back to 0.
- R3: In the first clock after every digit step, `seg_o` is all zero. In every other clock, `seg_o` shows the pattern of the driven digit.
- R4: Each clock that `ale_i` is high, the block takes `bus_i` as the address. The last such value is kept after `ale_i` falls. Address bits [2:0] select the register and bit 3 selects the nibble: 0 means bits [3:0], 1 means bits [7:4].
- R5: A write happens on the first clock of a high pulse on `wr_i`. It stores `bus_i` into the addressed nibble. Registers 0 to 5 show on `seg_o` for digits 0 to 5, with bit 0 as segment a, bit 6 as segment g and bit 7 as the decimal point. Register 6 drives `led_o` directly.
- R6: While `rd_i` is high, `bus_oe_o` is 1 and `bus_o` carries the addressed nibble of registers 0 to 6, which read back what was written. While `rd_i` is low, `bus_oe_o` and `bus_o` are 0.
- R7: Register 7 reads as {changed, key[6:0]}: the low nibble is key[3:0] and the high nibble is {changed, key[6:4]}. A key reads 1 when pressed. Writes to register 7 change nothing.
- R8: A filtered key level follows its raw input only after the input has been stable for DEB_CNT sample ticks, with one tick every 2^SAMPLE_LOG2 clocks. Shorter pulses are ignored.
- R9: Every change of a filtered key level, on press and on release, sets `irq_o`. `irq_o` stays high until a read strobe on register 7 ends, and then it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address phase marker |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| bus_i | input | 4 | Address or write nibble from the host |
| bus_o | output | 4 | Read nibble to the host |
| bus_oe_o | output | 1 | Host bus drive enable |
| key_i | input | 7 | Raw key switches, 1 = pressed |
| digit_en_o | output | 6 | One-hot digit enable |
| seg_o | output | 8 | Segment pattern of the driven digit |
| led_o | output | 8 | Status LEDs |
| irq_o | output | 1 | Key change interrupt |

## Verification
The bench writes a distinct pattern to both nibbles of every register and reads them all back. A swapped nibble select, or a write that lands in the wrong register, shows up as a wrong readback or a wrong LED value.

It follows a full scan rotation clock by clock against a count of edges since reset. A missing blank cycle, a digit held for the wrong time, or a wrong wrap point breaks the one-hot enable or the segment comparison.

Every key is pressed and released in turn. The bench checks that the interrupt stays low early in the filter window, rises after the window, survives until the status read ends, and then clears. This catches a filter that fires too soon, an interrupt that only covers presses, and a flag cleared at the wrong time. A short glitch and a write to the key register confirm that neither one disturbs the key state or the interrupt.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int NUM_DIGITS = 6;
  localparam int SEG_W      = 8;
  localparam int NUM_KEYS   = 7;
  localparam int NUM_LEDS   = 8;
  localparam int NIB_W      = 4;
  localparam int REG_SEL_W  = 3;
  localparam int NUM_WREGS  = NUM_DIGITS + 1;
  localparam logic [REG_SEL_W-1:0] LED_REG = REG_SEL_W'(NUM_DIGITS);
  localparam logic [REG_SEL_W-1:0] KEY_REG = REG_SEL_W'(NUM_DIGITS + 1);
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/fp_key_filter.sv
module fp_key_filter #(
  parameter int DEB_CNT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic state_o,
  output logic edge_o
);
  localparam int CW = $clog2(DEB_CNT + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          state_q;
  logic          differ;

  assign differ  = sync_q[1] != state_q;
  assign edge_o  = differ && tick_i && (cnt_q == CW'(DEB_CNT - 1));
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (!differ) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CW'(DEB_CNT - 1)) begin
          state_q <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // level may only move on a sample tick with the window filled
  p_state_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_q) |-> $past(tick_i));
endmodule

// File: rtl/fp_digit_scan.sv
module fp_digit_scan
  import fp_pkg::*;
#(
  parameter int SCAN_LOG2 = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  seg_t [NUM_DIGITS-1:0]        digits_i,
  output logic [NUM_DIGITS-1:0]        digit_en_o,
  output seg_t                         seg_o
);
  localparam int IDX_W = $clog2(NUM_DIGITS);

  logic [SCAN_LOG2-1:0] cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 blank_q;
  logic                 step;

  assign step = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      blank_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + SCAN_LOG2'(1);
      blank_q <= step;
      if (step) idx_q <= (idx_q == IDX_W'(NUM_DIGITS - 1)) ? '0 : idx_q + IDX_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_en
    assign digit_en_o[g] = (idx_q == IDX_W'(g));
  end

  assign seg_o = blank_q ? '0 : digits_i[idx_q];

  p_one_digit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(digit_en_o) == 1);
  p_blank_on_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idx_q) |-> (seg_o == '0));
endmodule

// File: rtl/fp_bus_regs.sv
module fp_bus_regs
  import fp_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ale_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [NIB_W-1:0]      bus_i,
  output logic [NIB_W-1:0]      bus_o,
  output logic                  bus_oe_o,
  input  logic [NUM_KEYS-1:0]   key_state_i,
  input  logic [NUM_KEYS-1:0]   key_edge_i,
  output seg_t [NUM_DIGITS-1:0] digits_o,
  output logic [NUM_LEDS-1:0]   led_o,
  output logic                  irq_o
);
  logic [NIB_W-1:0]     addr_q;
  logic                 wr_q, rd_q, change_q;
  seg_t [NUM_WREGS-1:0] regs_q;
  logic [REG_SEL_W-1:0] reg_sel;
  logic                 hi_sel, wr_fire, rd_done;
  seg_t                 rd_word;

  assign reg_sel = addr_q[REG_SEL_W-1:0];
  assign hi_sel  = addr_q[NIB_W-1];
  assign wr_fire = wr_i && !wr_q;
  assign rd_done = rd_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      change_q <= 1'b0;
      regs_q   <= '0;
    end else begin
      wr_q <= wr_i;
      rd_q <= rd_i;
      if (ale_i) addr_q <= bus_i;
      if (wr_fire && reg_sel != KEY_REG) begin
        if (hi_sel) regs_q[reg_sel][7:4] <= bus_i;
        else        regs_q[reg_sel][3:0] <= bus_i;
      end
      // new edge wins over a clear in the same cycle
      if (|key_edge_i)                        change_q <= 1'b1;
      else if (rd_done && reg_sel == KEY_REG) change_q <= 1'b0;
    end
  end

  always_comb begin
    if (reg_sel == KEY_REG) rd_word = {change_q, key_state_i};
    else                    rd_word = regs_q[reg_sel];
  end

  assign bus_o    = rd_i ? (hi_sel ? rd_word[7:4] : rd_word[3:0]) : '0;
  assign bus_oe_o = rd_i;
  assign digits_o = regs_q[NUM_DIGITS-1:0];
  assign led_o    = regs_q[LED_REG];
  assign irq_o    = change_q;

  p_irq_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|key_edge_i) |=> irq_o);
  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(rd_q && !rd_i)) |=> irq_o);
  p_regs_need_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_q));
endmodule

// File: rtl/fpanel_ctrl.sv
module fpanel_ctrl
  import fp_pkg::*;
#(
  parameter int SCAN_LOG2   = 10,
  parameter int SAMPLE_LOG2 = 8,
  parameter int DEB_CNT     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ale_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [NIB_W-1:0]      bus_i,
  output logic [NIB_W-1:0]      bus_o,
  output logic                  bus_oe_o,
  input  logic [NUM_KEYS-1:0]   key_i,
  output logic [NUM_DIGITS-1:0] digit_en_o,
  output logic [SEG_W-1:0]      seg_o,
  output logic [NUM_LEDS-1:0]   led_o,
  output logic                  irq_o
);
  logic [SAMPLE_LOG2-1:0] smp_q;
  logic                   smp_tick;
  logic [NUM_KEYS-1:0]    key_state, key_edge;
  seg_t [NUM_DIGITS-1:0]  digits;

  assign smp_tick = &smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else         smp_q <= smp_q + SAMPLE_LOG2'(1);
  end

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    fp_key_filter #(.DEB_CNT(DEB_CNT)) i_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (smp_tick),
      .raw_i   (key_i[k]),
      .state_o (key_state[k]),
      .edge_o  (key_edge[k])
    );
  end

  fp_bus_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ale_i       (ale_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .bus_i       (bus_i),
    .bus_o       (bus_o),
    .bus_oe_o    (bus_oe_o),
    .key_state_i (key_state),
    .key_edge_i  (key_edge),
    .digits_o    (digits),
    .led_o       (led_o),
    .irq_o       (irq_o)
  );

  fp_digit_scan #(.SCAN_LOG2(SCAN_LOG2)) i_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .digits_i   (digits),
    .digit_en_o (digit_en_o),
    .seg_o      (seg_o)
  );

  p_oe_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (!bus_oe_o && bus_o == '0));
endmodule

// File: tb/test_fpanel_ctrl.sv
`timescale 1ns/1ps
module test_fpanel_ctrl;
  localparam int SCAN_LOG2 = 3, SAMPLE_LOG2 = 2, DEB_CNT = 4;
  localparam int P = 1 << SCAN_LOG2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ale = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0] host_bus = '0;
  logic [6:0] keys = '0;
  logic [3:0] bus_o;
  logic       bus_oe;
  logic [5:0] digit_en;
  logic [7:0] seg, led;
  logic       irq;

  int checks = 0, errors = 0, ecnt = 0;
  logic       scan_chk = 1'b0;
  logic [7:0] shadow [7];

  always #2.5 clk = ~clk;

  fpanel_ctrl #(.SCAN_LOG2(SCAN_LOG2), .SAMPLE_LOG2(SAMPLE_LOG2), .DEB_CNT(DEB_CNT)) i_fpanel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .wr_i(wr), .rd_i(rd), .bus_i(host_bus),
    .bus_o(bus_o), .bus_oe_o(bus_oe), .key_i(keys), .digit_en_o(digit_en),
    .seg_o(seg), .led_o(led), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (!rst_n) ecnt <= 0; else ecnt <= ecnt + 1;

  // scan model: after e edges, digit (e/P)%6, blank at each multiple of P
  always @(negedge clk) if (scan_chk) begin
    int idx;
    bit blank;
    idx   = (ecnt / P) % 6;
    blank = (ecnt > 0) && (ecnt % P == 0);
    check("R2 digit enable", digit_en, 1 << idx);
    if (blank) check("R3 blank cycle", seg, 0);
    else       check("R5 segment pattern", seg, shadow[idx]);
  end

  task automatic bus_write(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); ale = 1'b1; host_bus = a;
    @(negedge clk); ale = 1'b0; host_bus = d;
    @(negedge clk); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); ale = 1'b1; host_bus = a;
    @(negedge clk); ale = 1'b0; host_bus = 4'h0;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); d = bus_o;
    check("R6 oe during read", bus_oe, 1);
    rd = 1'b0;
    @(negedge clk);
    check("R6 oe idle", {bus_oe, bus_o}, 0);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic [6:0] exp_keys;
    for (int r = 0; r < 7; r++) shadow[r] = 8'((r * 53 + 29) & 255);
    wait_clk(3);
    check("R1 reset seg", seg, 0);
    check("R1 reset led", led, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset oe", bus_oe, 0);
    check("R1 reset digit", digit_en, 1);
    rst_n = 1'b1;
    check("R1 after reset digit", digit_en, 1);

    // R4 R5: write both nibbles of every writable register
    for (int r = 0; r < 7; r++) begin
      bus_write(4'(r), shadow[r][3:0]);
      bus_write(4'(r) | 4'h8, shadow[r][7:4]);
    end
    check("R5 led register", led, shadow[6]);
    for (int r = 0; r < 7; r++) begin
      bus_read(4'(r), d);
      check("R4 R6 low nibble", d, shadow[r][3:0]);
      bus_read(4'(r) | 4'h8, d);
      check("R4 R6 high nibble", d, shadow[r][7:4]);
    end

    // R2 R3: one full rotation plus one digit, clock by clock
    scan_chk = 1'b1;
    wait_clk(7 * P);
    scan_chk = 1'b0;

    // R7 R8 R9: press then release each key
    exp_keys = '0;
    for (int k = 0; k < 7; k++) begin
      for (int ph = 0; ph < 2; ph++) begin
        keys[k] = (ph == 0);
        exp_keys[k] = (ph == 0);
        wait_clk(8);
        check("R8 filter not yet through", irq, 0);
        wait_clk(40);
        check("R9 irq on change", irq, 1);
        bus_read(4'hF, d);
        check("R7 R9 key high nibble", d, {1'b1, exp_keys[6:4]});
        check("R9 irq cleared by read", irq, 0);
        bus_read(4'h7, d);
        check("R7 key low nibble", d, exp_keys[3:0]);
      end
    end

    // R8: short glitch ignored
    keys[2] = 1'b1;
    wait_clk(5);
    keys[2] = 1'b0;
    wait_clk(40);
    check("R8 glitch irq", irq, 0);
    bus_read(4'h7, d);
    check("R8 glitch key state", d, 0);

    // R7: writes to key register ignored; irq kept until read
    keys[5] = 1'b1;
    wait_clk(48);
    bus_write(4'h7, 4'hF);
    bus_write(4'hF, 4'h0);
    check("R7 write keeps irq", irq, 1);
    bus_read(4'hF, d);
    check("R7 write ignored high", d, 4'b1010);
    bus_read(4'h7, d);
    check("R7 write ignored low", d, 0);
    check("R7 LEDs untouched", led, shadow[6]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule